// File: doc/BRIEF.md
# MDIO Station-Management Master

This block runs single read and write transactions to an Ethernet PHY over the two-wire management bus. The host presents one request: a direction flag, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. The block builds the serial frame and clocks it out on MDC. It shifts the PHY's reply back in and reports completion with a one-cycle done pulse. Read data and an error flag are held until the next request.

MDC is derived from the system clock by a half-period divider, `HALF_DIV` system cycles per MDC phase. The default of 25 gives 2.5 MHz from a 125 MHz clock. MDIO is driven through an output enable so that the line can be released to the PHY. The returning line passes through a two-flop synchroniser before it is sampled.

On a read, the block checks the turnaround bit that the PHY drives. If that bit is not low, the block keeps clocking a released bus for 32 recovery cycles. It then finishes with the error flag set and leaves the read data untouched.

Top module: `mdio_master`

## Requirements
- R1: After reset and between transactions, busy and done are 0, MDC is low and the MDIO output enable is 0.
- R2: Every frame begins with 32 MDC cycles with MDIO driven to 1.
- R3: After the preamble come the start bits 0 then 1, and then the opcode: 1,0 for a read and 0,1 for a write.
- R4: Next come the 5-bit PHY address and then the 5-bit register address, each sent most significant bit first.
- R5: Each MDC phase lasts HALF_DIV system clocks. MDIO and its enable change only while MDC is low, so both hold steady while MDC is high.
- R6: A write drives the turnaround as 1 then 0 and then 16 data bits, most significant bit first. It then gives one more MDC cycle with MDIO released, which makes 65 MDC cycles before done.
- R7: A read releases MDIO from the first turnaround slot (slot 46, counting from 0) onward. It samples the second turnaround slot and expects 0. It samples 16 data bits most significant bit first, near the end of each high phase. After one trailing idle MDC cycle, which makes 65 MDC cycles in all, the captured word appears on rd_data with rd_err low. rd_data changes only in a done cycle.
- R8: If the sampled turnaround bit is 1, the block gives 32 further MDC cycles with MDIO released, which makes 80 in all. It then signals done with rd_err high, and rd_data keeps its previous value.
- R9: A request is accepted only while busy is low. A request raised while busy is high has no effect on the frame in progress and starts no later transaction.
- R10: Busy rises the cycle after acceptance and stays high until the done pulse. Done lasts exactly one cycle, and busy is already low in that cycle, so a request held then is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_read | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last successfully read word |
| rd_err | output | 1 | Last transaction ended on a bad turnaround |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
Two events can share a cycle: the done pulse of one transaction and the acceptance of the next. The bench provokes this by holding req_valid high across the end of a transaction. In the done cycle it requires busy low and done high. One cycle later it requires busy high and done low. The held request must then produce a full second frame of 65 MDC cycles. A second overlap, a request raised in the middle of a frame, is judged by comparing every captured frame bit against the first request and by counting done pulses.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_W = 64;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 5;
    localparam int SLOT_W  = 7;

    // Slot indices inside a frame (slot 0 is the first preamble bit)
    localparam logic [SLOT_W-1:0] SLOT_TA_FIRST   = 7'd46;
    localparam logic [SLOT_W-1:0] SLOT_TA_CHECK   = 7'd47;
    localparam logic [SLOT_W-1:0] SLOT_DATA_FIRST = 7'd48;
    localparam logic [SLOT_W-1:0] SLOT_DATA_LAST  = 7'd63;
    localparam logic [SLOT_W-1:0] SLOT_FINAL      = 7'd64;
    localparam logic [SLOT_W-1:0] SLOT_RECOV_LAST = 7'd31;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_RECOVER
    } mdio_state_e;

    typedef struct packed {
        mdio_state_e         state;
        logic [SLOT_W-1:0]   slot;
        logic                mdc;
        logic                mdio_o;
        logic                mdio_oe;
        logic                is_read;
        logic [FRAME_W-1:0]  shift;
        logic [DATA_W-1:0]   cap;
        logic [DATA_W-1:0]   rdata;
        logic                done;
        logic                err;
    } mdio_regs_t;
endpackage

// File: rtl/mdio_tick_gen.sv
module mdio_tick_gen #(
    parameter int HALF_DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = $clog2(HALF_DIV + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart || cnt_q == '0) begin
            cnt_d = RELOAD;
        end else begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = (cnt_q == '0) && !restart;

    // R5: the phase counter never leaves its reload range
    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= RELOAD);
endmodule

// File: rtl/mdio_sync.sv
module mdio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q[0] <= 1'b1;
                else        ff_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q[i] <= 1'b1;
                else        ff_q[i] <= ff_q[i-1];
            end
        end
    end

    assign q = ff_q[STAGES-1];
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV    = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_read,
    input  logic [ADDR_W-1:0] req_phy,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    mdio_regs_t r_d, r_q;
    logic tick;
    logic mdio_s;
    logic accept;
    logic [FRAME_W-1:0] frame;
    logic [SLOT_W-1:0]  next_slot;
    logic               next_oe;

    assign accept = (r_q.state == ST_IDLE) && req_valid;

    mdio_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .tick    (tick)
    );

    mdio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (mdio_i),
        .q     (mdio_s)
    );

    always_comb begin
        frame = {{32{1'b1}}, 2'b01,
                 req_read ? 2'b10 : 2'b01,
                 req_phy, req_reg,
                 req_read ? 2'b00 : 2'b10,
                 req_read ? {DATA_W{1'b0}} : req_wdata};
        next_slot = r_q.slot + 1'b1;
        next_oe   = r_q.is_read ? (next_slot < SLOT_TA_FIRST)
                                : (next_slot < SLOT_FINAL);

        r_d      = r_q;
        r_d.done = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (accept) begin
                    r_d.state   = ST_FRAME;
                    r_d.slot    = '0;
                    r_d.mdc     = 1'b0;
                    r_d.mdio_oe = 1'b1;
                    r_d.mdio_o  = frame[FRAME_W-1];
                    r_d.shift   = {frame[FRAME_W-2:0], 1'b0};
                    r_d.is_read = req_read;
                    r_d.cap     = '0;
                    r_d.err     = 1'b0;
                end
            end
            ST_FRAME: begin
                if (tick) begin
                    if (!r_q.mdc) begin
                        r_d.mdc = 1'b1;
                    end else if (r_q.is_read && r_q.slot == SLOT_TA_CHECK && mdio_s) begin
                        r_d.state   = ST_RECOVER;
                        r_d.slot    = '0;
                        r_d.mdc     = 1'b0;
                        r_d.mdio_oe = 1'b0;
                        r_d.mdio_o  = 1'b0;
                    end else if (r_q.slot == SLOT_FINAL) begin
                        r_d.state   = ST_IDLE;
                        r_d.mdc     = 1'b0;
                        r_d.mdio_oe = 1'b0;
                        r_d.mdio_o  = 1'b0;
                        r_d.done    = 1'b1;
                        if (r_q.is_read) r_d.rdata = r_q.cap;
                    end else begin
                        if (r_q.is_read && r_q.slot >= SLOT_DATA_FIRST
                            && r_q.slot <= SLOT_DATA_LAST) begin
                            r_d.cap = {r_q.cap[DATA_W-2:0], mdio_s};
                        end
                        r_d.slot    = next_slot;
                        r_d.mdc     = 1'b0;
                        r_d.mdio_oe = next_oe;
                        r_d.mdio_o  = next_oe ? r_q.shift[FRAME_W-1] : 1'b0;
                        r_d.shift   = {r_q.shift[FRAME_W-2:0], 1'b0};
                    end
                end
            end
            ST_RECOVER: begin
                if (tick) begin
                    if (!r_q.mdc) begin
                        r_d.mdc = 1'b1;
                    end else if (r_q.slot == SLOT_RECOV_LAST) begin
                        r_d.state = ST_IDLE;
                        r_d.mdc   = 1'b0;
                        r_d.done  = 1'b1;
                        r_d.err   = 1'b1;
                    end else begin
                        r_d.slot = next_slot;
                        r_d.mdc  = 1'b0;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.state != ST_IDLE);
    assign done    = r_q.done;
    assign rd_data = r_q.rdata;
    assign rd_err  = r_q.err;
    assign mdc     = r_q.mdc;
    assign mdio_o  = r_q.mdio_o;
    assign mdio_oe = r_q.mdio_oe;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));
    assert_mdio_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));
    assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rd_data));
    assert_err_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_err) |-> done);
    assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    localparam int HDIV = 4;
    localparam int NVEC = 7;
    // {read, phy[4:0], reg[4:0], wdata[15:0], phy_reply[15:0], bad_ta}
    localparam logic [43:0] VEC [NVEC] = '{
        {1'b0, 5'h01, 5'h00, 16'h1234, 16'h0000, 1'b0},
        {1'b1, 5'h1F, 5'h1F, 16'h0000, 16'hA5C3, 1'b0},
        {1'b0, 5'h10, 5'h0A, 16'hFFFF, 16'h0000, 1'b0},
        {1'b1, 5'h00, 5'h01, 16'h0000, 16'h8001, 1'b0},
        {1'b1, 5'h05, 5'h11, 16'h0000, 16'h3C3C, 1'b1},
        {1'b0, 5'h15, 5'h15, 16'h0000, 16'h0000, 1'b0},
        {1'b1, 5'h0A, 5'h1E, 16'h0000, 16'h7FFE, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_read = 1'b0;
    logic [4:0] req_phy = '0, req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic busy, done, rd_err, mdc, mdio_o, mdio_oe, mdio_line;
    logic [15:0] rd_data;

    logic phy_drv = 1'b0, phy_bit = 1'b0, phy_rd = 1'b0, phy_bad = 1'b0;
    logic [15:0] phy_data = '0;

    int checks = 0, fails = 0;
    int cyc = 0, last_rise = 0, mdc_period = 0;
    int rise_cnt = 0, base = 0, viol = 0, done_cnt = 0;
    logic hold_o = 1'b0, hold_oe = 1'b0;
    logic seen_b [0:127];
    logic seen_oe [0:127];
    logic [15:0] exp_rd = '0;

    always #4 clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);

    mdio_master #(.HALF_DIV(HDIV)) u_mdio_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .rd_err(rd_err),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    always @(posedge mdc) begin
        int idx;
        idx = rise_cnt - base;
        if (idx >= 0 && idx < 128) begin
            seen_b[idx]  = mdio_o;
            seen_oe[idx] = mdio_oe;
        end
        rise_cnt++;
        mdc_period = cyc - last_rise;
        last_rise  = cyc;
        hold_o  = mdio_o;
        hold_oe = mdio_oe;
    end

    // PHY model: changes the line after each falling MDC edge
    always @(negedge mdc) begin
        int s;
        s = rise_cnt - base;
        if (phy_rd && s == 47) begin
            phy_drv = 1'b1; phy_bit = phy_bad;
        end else if (phy_rd && !phy_bad && s >= 48 && s <= 63) begin
            phy_drv = 1'b1; phy_bit = phy_data[63-s];
        end else begin
            phy_drv = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && mdc && (mdio_o !== hold_o || mdio_oe !== hold_oe)) viol++;
        if (done) done_cnt++;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic start_txn(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd, input logic [15:0] reply, input logic bad);
        phy_rd = rd; phy_bad = bad; phy_data = reply; phy_drv = 1'b0;
        base = rise_cnt;
        req_read = rd; req_phy = phy; req_reg = rg; req_wdata = wd;
        req_valid = 1'b1;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic check_frame(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                               input logic [15:0] wd, input logic bad);
        logic [45:0] hdr;
        logic [17:0] tail;
        int rises;
        bit ok;
        hdr = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg};
        rises = rise_cnt - base;
        chk(rises == (bad ? 80 : 65), bad ? "R8" : (rd ? "R7" : "R6"),
            "MDC cycle count", rises, bad ? 80 : 65);
        ok = 1'b1;
        for (int k = 0; k < 32; k++) if (seen_b[k] !== 1'b1 || seen_oe[k] !== 1'b1) ok = 1'b0;
        chk(ok, "R2", "preamble ones", 0, 0);
        ok = 1'b1;
        for (int k = 32; k < 36; k++) if (seen_b[k] !== hdr[45-k] || seen_oe[k] !== 1'b1) ok = 1'b0;
        chk(ok, "R3", "start and opcode", {seen_b[32], seen_b[33], seen_b[34], seen_b[35]}, hdr[13:10]);
        ok = 1'b1;
        for (int k = 36; k < 46; k++) if (seen_b[k] !== hdr[45-k] || seen_oe[k] !== 1'b1) ok = 1'b0;
        chk(ok, "R4", "phy and register address", 0, {phy, rg});
        if (!rd) begin
            tail = {2'b10, wd};
            ok = 1'b1;
            for (int k = 46; k < 64; k++) if (seen_b[k] !== tail[63-k] || seen_oe[k] !== 1'b1) ok = 1'b0;
            chk(ok, "R6", "turnaround and write data", 0, tail);
            chk(seen_oe[64] === 1'b0, "R6", "released final cycle", seen_oe[64], 0);
        end else begin
            ok = 1'b1;
            for (int k = 46; k < rises; k++) if (seen_oe[k] !== 1'b0) ok = 1'b0;
            chk(ok, bad ? "R8" : "R7", "line released after address", 0, 0);
        end
    endtask

    initial begin
        for (int k = 0; k < 128; k++) begin seen_b[k] = 1'b0; seen_oe[k] = 1'b0; end
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1", "reset busy/done", {busy, done}, 0);
        chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1", "reset mdc/oe", {mdc, mdio_oe}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(rd_data === 16'h0 && rd_err === 1'b0, "R1", "reset read outputs", {rd_err, rd_data}, 0);

        // table-driven transactions
        for (int i = 0; i < NVEC; i++) begin
            logic [43:0] v;
            v = VEC[i];
            start_txn(v[43], v[42:38], v[37:33], v[32:17], v[16:1], v[0]);
            @(negedge clk);
            req_valid = 1'b0;
            chk(busy === 1'b1, "R10", "busy after accept", busy, 1);
            wait_done();
            chk(busy === 1'b0, "R10", "busy low in done cycle", busy, 0);
            if (v[43] && !v[0]) exp_rd = v[16:1];
            chk(rd_data === exp_rd, v[0] ? "R8" : "R7", "rd_data", rd_data, exp_rd);
            chk(rd_err === v[0], v[0] ? "R8" : "R7", "rd_err", rd_err, v[0]);
            @(negedge clk);
            chk(done === 1'b0, "R10", "done single cycle", done, 0);
            check_frame(v[43], v[42:38], v[37:33], v[32:17], v[0]);
            chk(mdc_period == 2 * HDIV, "R5", "MDC period in clocks", mdc_period, 2 * HDIV);
            repeat (5) @(negedge clk);
            chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1", "idle between frames", {mdc, mdio_oe}, 0);
        end

        // R9: request raised mid-frame is ignored
        begin
            int d0;
            d0 = done_cnt;
            start_txn(1'b0, 5'h0C, 5'h03, 16'hBEEF, 16'h0, 1'b0);
            @(negedge clk);
            req_valid = 1'b0;
            repeat (100) @(negedge clk);
            req_read = 1'b1; req_phy = 5'h1A; req_reg = 5'h1C; req_wdata = 16'h0F0F;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            wait_done();
            @(negedge clk);
            check_frame(1'b0, 5'h0C, 5'h03, 16'hBEEF, 1'b0);
            repeat (200) @(negedge clk);
            chk(done_cnt == d0 + 1, "R9", "single done for busy-time request", done_cnt - d0, 1);
            chk(busy === 1'b0, "R9", "no late transaction", busy, 0);
        end

        // R10: request held across done is accepted in the done cycle
        begin
            start_txn(1'b0, 5'h02, 5'h04, 16'h5A5A, 16'h0, 1'b0);
            @(negedge clk);
            wait_done();
            chk(busy === 1'b0 && done === 1'b1, "R10", "done with busy low", {busy, done}, 2'b01);
            @(negedge clk);
            req_valid = 1'b0;
            chk(busy === 1'b1 && done === 1'b0, "R10", "held request accepted", {busy, done}, 2'b10);
            base = rise_cnt;
            wait_done();
            chk(rise_cnt - base == 65, "R10", "second frame length", rise_cnt - base, 65);
            @(negedge clk);
        end

        chk(viol == 0, "R5", "MDIO changes while MDC high", viol, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule